// File: doc/BRIEF.md
# Fixed-Frequency PWM Gate Controller with Blanked Current Limit

This block drives the gate of a single power switch at a fixed frequency. A free-running cycle counter stands in for a sawtooth ramp. Each time the counter wraps, a new period begins, the on-latch sets and the gate rises. The latch clears when the period position reaches the on-time computed from the error code, or when the current-limit flag is seen after a blanking window. The on-time shrinks linearly as the error code grows. Below a knee value of the error code the on-time stays at its maximum. Above the knee it is clamped to a minimum.

The error code is captured once, at the period boundary, so that a pulse already in progress keeps its length. The enable input removes the gate drive at once. After enable returns, no pulse starts until the next period boundary. The default parameters give a 100 kHz period from a 100 MHz clock (1000 clocks), a 67 % maximum duty, a 2 % minimum on-time and a 180 ns blanking window (18 clocks).

Top module: `pwm_gate_ctl`

## Requirements
- R1: A period lasts PERIOD_CLKS (1000) clocks. In cycle 0 of every period that starts with `en` high, `cyc_start` is high for exactly one cycle and `gate` rises in that same cycle.
- R2: For an error code e above ERR_KNEE (32), the gate stays high for MAX_ON_CLKS - SLOPE*(e - ERR_KNEE) clocks, where SLOPE is 4. A larger code therefore gives a shorter pulse.
- R3: `gate` is never high at a period position of MAX_ON_CLKS (670) or later, so the duty never exceeds 67 %.
- R4: When the R2 formula would give fewer than MIN_ON_CLKS (20) clocks, the pulse lasts exactly MIN_ON_CLKS clocks. For example, e = 194 gives 22 clocks and e = 195 or 255 gives 20.
- R5: For any error code of ERR_KNEE or lower, the pulse lasts MAX_ON_CLKS clocks.
- R6: If `cl_trip` is high in a cycle where `gate` is high and the period position is BLANK_CLKS (18) or more, `gate` is low from the next cycle. It stays low until the next period starts, even if `cl_trip` goes low again.
- R7: `cl_trip` has no effect at period positions 0 to BLANK_CLKS-1.
- R8: A current-limit trip that is seen after blanking ends shortens the pulse below MIN_ON_CLKS. A trip at position 18 gives a pulse of 19 clocks.
- R9: While `en` is low, `gate` is low in that same cycle. When `en` returns in the middle of a period, no pulse appears before the next boundary. When `en` is low at a boundary, no period starts there and `cyc_start` stays low.
- R10: The error code is sampled only at the clock edge that starts a period. A change later in the period does not alter the current pulse.
- R11: During reset, `gate` and `cyc_start` are low. After reset is released, the first `cyc_start` comes PERIOD_CLKS cycles later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low forces the gate off at once |
| err_code | input | ERR_W (8) | Error value; a higher value gives a shorter pulse |
| cl_trip | input | 1 | Current-limit comparator flag |
| gate | output | 1 | Gate drive for the power switch |
| cyc_start | output | 1 | One-cycle strobe in the first cycle of each started period |

## Verification
The current-limit trip can arrive in the same cycle that blanking ends, while the minimum on-time is still running. The bench drives `cl_trip` exactly at position 18 with the error code at its full-scale value. It then expects a 19-clock pulse, which shows that the trip beats the 20-clock minimum. The bench also places trips at positions 10 and 17, and expects them to have no effect there. A behavioural reference model that tracks the period position runs beside the design. It is compared with `gate` and `cyc_start` on every clock, including cycles where enable falls in the middle of a pulse and where it is low across a boundary.

// File: rtl/pwm_gate_ctl.sv
module pwm_gate_ctl #(
  parameter int PERIOD_CLKS = 1000,
  parameter int MAX_ON_CLKS = 670,
  parameter int MIN_ON_CLKS = 20,
  parameter int BLANK_CLKS  = 18,
  parameter int ERR_W       = 8,
  parameter int ERR_KNEE    = 32,
  parameter int SLOPE       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ERR_W-1:0] err_code,
  input  logic             cl_trip,
  output logic             gate,
  output logic             cyc_start
);
  localparam int CW = $clog2(PERIOD_CLKS);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] on_len_q;
  logic [CW-1:0] on_len_d;
  logic          on_q;
  logic          strobe_q;

  wire wrap      = (cnt_q == CW'(PERIOD_CLKS - 1));
  wire start     = wrap && en;
  wire pulse_end = (cnt_q == on_len_q - CW'(1));
  wire max_hit   = (cnt_q >= CW'(MAX_ON_CLKS - 1));
  wire cl_hit    = cl_trip && (cnt_q >= CW'(BLANK_CLKS));

  always_comb begin
    int excess;
    int reduce;
    excess = int'(err_code) - ERR_KNEE;
    reduce = excess * SLOPE;
    if (excess <= 0)
      on_len_d = CW'(MAX_ON_CLKS);
    else if (reduce >= MAX_ON_CLKS - MIN_ON_CLKS)
      on_len_d = CW'(MIN_ON_CLKS);
    else
      on_len_d = CW'(MAX_ON_CLKS - reduce);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      on_len_q <= CW'(MAX_ON_CLKS);
      on_q     <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      cnt_q    <= wrap ? '0 : cnt_q + CW'(1);
      strobe_q <= start;
      if (start) begin
        on_q     <= 1'b1;
        on_len_q <= on_len_d;
      end else if (!en || pulse_end || max_hit || cl_hit) begin
        on_q <= 1'b0;
      end
    end
  end

  assign gate      = on_q && en;
  assign cyc_start = strobe_q;
endmodule

// File: rtl/pwm_gate_ctl_chk.sv
module pwm_gate_ctl_chk #(
  parameter int PERIOD_CLKS = 1000,
  parameter int MAX_ON_CLKS = 670,
  parameter int MIN_ON_CLKS = 20,
  parameter int BLANK_CLKS  = 18
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           en,
  input logic                           cl_trip,
  input logic                           gate,
  input logic                           cyc_start,
  input logic [$clog2(PERIOD_CLKS)-1:0] cnt_q,
  input logic [$clog2(PERIOD_CLKS)-1:0] on_len_q
);
  localparam int CW = $clog2(PERIOD_CLKS);

  assert_strobe_at_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start |-> cnt_q == '0);

  assert_strobe_lifts_gate_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_start && en |-> gate);

  assert_max_duty_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gate |-> cnt_q < CW'(MAX_ON_CLKS));

  assert_len_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    on_len_q >= CW'(MIN_ON_CLKS) && on_len_q <= CW'(MAX_ON_CLKS));

  assert_cl_turns_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    gate && cl_trip && cnt_q >= CW'(BLANK_CLKS) |=> !gate);

  assert_no_early_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate) && en |-> $past(cnt_q) >= CW'(BLANK_CLKS));

  assert_disable_holds_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !gate);
endmodule

bind pwm_gate_ctl pwm_gate_ctl_chk #(
  .PERIOD_CLKS(PERIOD_CLKS),
  .MAX_ON_CLKS(MAX_ON_CLKS),
  .MIN_ON_CLKS(MIN_ON_CLKS),
  .BLANK_CLKS (BLANK_CLKS)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .cl_trip  (cl_trip),
  .gate     (gate),
  .cyc_start(cyc_start),
  .cnt_q    (cnt_q),
  .on_len_q (on_len_q)
);

// File: tb/pwm_gate_ctl_tb_top.sv
module pwm_gate_ctl_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int P = 1000, MAXON = 670, MINON = 20, BLANK = 18;
  localparam int EW = 8, KNEE = 32, SLOPE = 4;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, cl = 1'b0;
  logic [EW-1:0] err = '0;
  wire gate, cyc_start;

  always #5 clk = ~clk;

  pwm_gate_ctl #(.PERIOD_CLKS(P), .MAX_ON_CLKS(MAXON), .MIN_ON_CLKS(MINON),
                 .BLANK_CLKS(BLANK), .ERR_W(EW), .ERR_KNEE(KNEE), .SLOPE(SLOPE))
    dut_i (.clk(clk), .rst_n(rst_n), .en(en), .err_code(err), .cl_trip(cl),
           .gate(gate), .cyc_start(cyc_start));

  int n_chk = 0, n_fail = 0;
  int pos = 0, len_m = 0, run_w = 0, last_w = 0;
  bit on_m = 0, stb_m = 0;

  function automatic int exp_len(int e);
    int r;
    if (e <= KNEE) return MAXON;
    r = (e - KNEE) * SLOPE;
    if (r >= MAXON - MINON) return MINON;
    return MAXON - r;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      pos = 0; on_m = 0; stb_m = 0; len_m = 0;
    end else begin
      if (pos == P - 1 && en) begin
        on_m = 1; stb_m = 1; len_m = exp_len(int'(err));
      end else begin
        stb_m = 0;
        if (!en) on_m = 0;
        else if (on_m && (pos == len_m - 1 || (cl && pos >= BLANK))) on_m = 0;
      end
      pos = (pos == P - 1) ? 0 : pos + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(gate == (on_m && en), "R1 cycle model gate", int'(gate), int'(on_m && en));
      chk(cyc_start == stb_m, "R1 cycle model strobe", int'(cyc_start), int'(stb_m));
      if (gate) run_w++;
      else if (run_w > 0) begin last_w = run_w; run_w = 0; end
    end
  end

  task automatic wait_pos(int k);
    do begin @(posedge clk); #1; end while (pos != k);
  endtask

  task automatic run_period(int e, int cl_from, int cl_to, int expw, string req);
    wait_pos(P - 1);
    err = EW'(e);
    last_w = 0;
    if (cl_from >= 0) begin
      wait_pos(cl_from); cl = 1'b1;
      wait_pos(cl_to);   cl = 1'b0;
    end
    wait_pos(P - 2);
    chk(last_w == expw, req, last_w, expw);
  endtask

  initial begin
    #2000000;
    chk(1'b0, "watchdog R1..", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(gate == 1'b0, "R11 reset gate", int'(gate), 0);
    chk(cyc_start == 1'b0, "R11 reset strobe", int'(cyc_start), 0);
    @(posedge clk); #1;
    rst_n = 1'b1; en = 1'b1;
    n = 0;
    forever begin
      @(negedge clk);
      if (cyc_start) break;
      n++;
    end
    chk(n == P, "R11 first strobe delay", n, P);

    run_period(0,          -1, -1, MAXON, "R5 err zero");
    run_period(KNEE,       -1, -1, MAXON, "R5 err at knee");
    run_period(KNEE + 1,   -1, -1, 666,   "R2 knee plus one");
    run_period(KNEE + 10,  -1, -1, 630,   "R2 knee plus ten");
    run_period(KNEE + 100, -1, -1, 270,   "R2 knee plus hundred");
    run_period(KNEE + 162, -1, -1, 22,    "R4 just above min");
    run_period(KNEE + 163, -1, -1, MINON, "R4 clamp");
    run_period(255,        -1, -1, MINON, "R4 full scale");
    run_period(0, 10, 11, MAXON, "R7 trip early in blanking");
    run_period(0, BLANK - 1, BLANK, MAXON, "R7 trip last blanked cycle");
    run_period(0, BLANK, BLANK + 1, BLANK + 1, "R6 trip at blank end");
    run_period(0, 100, 400, 101, "R6 trip held long");
    run_period(0, -1, -1, MAXON, "R6 next period recovers");
    run_period(255, BLANK, BLANK + 1, BLANK + 1, "R8 trip beats min on");
    run_period(0, 600, 700, 601, "R3 trip late");

    wait_pos(P - 1); err = '0; last_w = 0;
    wait_pos(5); err = 8'd255;
    wait_pos(P - 2);
    chk(last_w == MAXON, "R10 mid-period err change", last_w, MAXON);
    run_period(255, -1, -1, MINON, "R10 new err used next period");

    wait_pos(P - 1); err = '0; last_w = 0;
    wait_pos(100); en = 1'b0;
    @(negedge clk);
    chk(gate == 1'b0, "R9 gate off same cycle", int'(gate), 0);
    wait_pos(300); en = 1'b1;
    wait_pos(500);
    @(negedge clk);
    chk(gate == 1'b0, "R9 no restart mid-period", int'(gate), 0);
    wait_pos(P - 2);
    chk(last_w == 100, "R9 cut pulse width", last_w, 100);
    wait_pos(P - 1); en = 1'b0;
    wait_pos(0);
    @(negedge clk);
    chk(cyc_start == 1'b0, "R9 no start while disabled", int'(cyc_start), 0);
    chk(gate == 1'b0, "R9 no pulse while disabled", int'(gate), 0);
    wait_pos(10); en = 1'b1;
    run_period(0, -1, -1, MAXON, "R9 resume at boundary");

    wait_pos(0);
    @(negedge clk);
    chk(cyc_start == 1'b1, "R1 strobe in cycle 0", int'(cyc_start), 1);
    chk(gate == 1'b1, "R1 gate rises with strobe", int'(gate), 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!cyc_start);
    chk(n == P, "R1 period length", n, P);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule